// File: doc/BRIEF.md
# Carry-Save Multiply-Add Unit

This block is one computational element of a DSP datapath that never leaves redundant form. Every data operand arrives as a pair of vectors (a sum vector and a carry vector) whose arithmetic total is the operand's value. The result leaves the same way, so it can be wired straight back into this unit or into a neighbour without a carry-propagate adder in between. Only the coefficient `A` is an ordinary binary word. All values are two's complement and are taken modulo 2^N.

A five-bit configuration word picks the chained form. One form adds two pairs, multiplies that sum by `A`, and adds a third pair. The other form multiplies a pair by `A` and adds the sum of two more pairs. An addition-only form and a multiplication-only form are also available. Any operand can be negated. The multiplicand pair is recoded straight into radix-4 Booth digits in the range -2..+2. Each digit needs only its own two bit positions and those of the two groups below it. The partial products, the other operands and all correction constants then go into one chain of 4:2 compressors.

Both the operand side and the result side use a valid/ready handshake with a single output register. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. The result stays put until a cycle in which `out_ready` is high. `in_ready` is high exactly when the output register is empty or is being drained in the same cycle. A new operation can therefore replace a drained result on the same edge, and a stalled result blocks new input.

Top module: `csmac_unit`

## Requirements
- R1: With `in_cfg[1:0]` = 0, the total `out_sum + out_carry` (mod 2^N) equals A·(X+Y)+K, where X, Y, K are the totals of their input pairs.
- R2: With `in_cfg[1:0]` = 1, the output total equals A·K+(X+Y).
- R3: With `in_cfg[1:0]` = 2, the output total equals X+Y+K, and `in_coef` has no effect.
- R4: With `in_cfg[1:0]` = 3, the output total equals A·(X+Y). The K pair and its negate bit have no effect; in particular, a zero coefficient gives a total of zero.
- R5: Negate bits `in_cfg[2]` (X), `in_cfg[3]` (Y) and `in_cfg[4]` (K) each replace the named operand by its two's complement negative, in every format.
- R6: Results stay exact for highly redundant multiplicand pairs (both vectors all ones, alternating bit patterns) and for the extreme coefficients 0x8000, 0xFFFF, 0x7FFF and 1. Every internal Booth digit is one of -2, -1, 0, +1, +2.
- R7: An operation is taken when `in_valid && in_ready`. `out_valid` is high in the cycle after that edge. `out_valid` falls after a cycle with `out_ready` high and no new operation taken.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_sum`/`out_carry` hold their values.
- R9: During and right after reset, `out_valid` is 0, `out_sum` and `out_carry` are 0, and `in_ready` is 1.
- R10: An output pair fed back unchanged as an operand pair of a later operation gives the total predicted by composing the two operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_cfg | input | 5 | [1:0] format, [2] negate X, [3] negate Y, [4] negate K |
| in_coef | input | N | Binary coefficient A |
| in_x_sum | input | N | Operand X, sum vector |
| in_x_carry | input | N | Operand X, carry vector |
| in_y_sum | input | N | Operand Y, sum vector |
| in_y_carry | input | N | Operand Y, carry vector |
| in_k_sum | input | N | Operand K, sum vector |
| in_k_carry | input | N | Operand K, carry vector |
| out_valid | output | 1 | Result pair held in the output register |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_sum | output | N | Result sum vector |
| out_carry | output | N | Result carry vector |

## Verification
Random operand pairs in each of the four formats show whether the right operands reach the multiplier and the adder side. Randomising the coefficient in the addition-only format and K in the multiply-only format shows that the unused inputs are really cut off. Sweeping all eight negate combinations across the formats shows whether each correction constant lands on the right side of the multiplier. All-ones and alternating multiplicand pairs against extreme coefficients drive the Booth recoder through its largest local transfers, which a separate carry-propagate design would never see. A stall-then-release sequence and a fed-back result pair show the handshake ordering and that the redundant output is a valid operand.

// File: rtl/csmac_pkg.sv
package csmac_pkg;

  // Chained form selected by the low two configuration bits
  typedef enum logic [1:0] {
    FMT_MAC_PRE  = 2'd0,  // A*(X+Y)+K
    FMT_MAC_POST = 2'd1,  // A*K+(X+Y)
    FMT_ADD3     = 2'd2,  // X+Y+K
    FMT_MUL      = 2'd3   // A*(X+Y)
  } fmt_e;

  typedef struct packed {
    logic neg_k;
    logic neg_y;
    logic neg_x;
    fmt_e fmt;
  } cfg_t;

endpackage

// File: rtl/csmac_csa42.sv
// 4:2 compressor built from two 3:2 rows; carries shifted left, top carry dropped (mod 2^W).
module csmac_csa42 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  logic [W-1:0] s1, maj1, c1, maj2;

  assign s1   = a ^ b ^ c;
  assign maj1 = (a & b) | (a & c) | (b & c);
  assign c1   = maj1 << 1;
  assign s    = s1 ^ c1 ^ d;
  assign maj2 = (s1 & c1) | (s1 & d) | (c1 & d);
  assign cy   = maj2 << 1;
endmodule

// File: rtl/csmac_booth_recode.sv
// Carry-save pair to radix-4 digits in -2..+2 using two local transfer steps per group.
module csmac_booth_recode #(
  parameter int W = 16,
  localparam int G = W / 2
) (
  input  logic [W-1:0] ps,
  input  logic [W-1:0] pc,
  output logic [G-1:0] dig_neg,
  output logic [G-1:0] dig_one,
  output logic [G-1:0] dig_two
);
  logic [1:0] t1a [G-1];
  logic       t2a [G-1];

  for (genvar j = 0; j < G; j++) begin : g_grp
    logic [2:0]        v;
    logic [1:0]        t1, prev1;
    logic              t2, prev2;
    logic signed [4:0] w, u, r, d;

    // group value 0..6 from four bits
    assign v  = {2'b0, ps[2*j]} + {2'b0, pc[2*j]}
              + {1'b0, ps[2*j+1], 1'b0} + {1'b0, pc[2*j+1], 1'b0};
    assign t1 = (v == 3'd6) ? 2'd2 : ((v >= 3'd2) ? 2'd1 : 2'd0);
    assign w  = $signed({2'b0, v}) - $signed({1'b0, t1, 2'b00});

    if (j == 0) begin : g_first
      assign prev1 = 2'd0;
      assign prev2 = 1'b0;
    end else begin : g_rest
      assign prev1 = t1a[j-1];
      assign prev2 = t2a[j-1];
    end

    assign u  = w + $signed({3'b0, prev1});       // -2..3
    assign t2 = (u >= 5'sd2);
    assign r  = t2 ? (u - 5'sd4) : u;             // -2..1
    assign d  = r + $signed({4'b0, prev2});       // -2..2

    if (j < G - 1) begin : g_pub
      assign t1a[j] = t1;
      assign t2a[j] = t2;
    end

    assign dig_neg[j] = d[4];
    assign dig_one[j] = (d == 5'sd1) || (d == -5'sd1);
    assign dig_two[j] = (d == 5'sd2) || (d == -5'sd2);
  end
endmodule

// File: rtl/csmac_ppgen.sv
// Partial products d_j*A*4^j, negatives as inverted rows plus a correction bit at 2j.
module csmac_ppgen #(
  parameter int W = 16,
  localparam int G = W / 2
) (
  input  logic [W-1:0]        coef,
  input  logic [G-1:0]        dig_neg,
  input  logic [G-1:0]        dig_one,
  input  logic [G-1:0]        dig_two,
  output logic [G-1:0][W-1:0] pp,
  output logic [W-1:0]        corr
);
  for (genvar j = 0; j < G; j++) begin : g_row
    logic [W-1:0] mag, sgn;
    assign mag = dig_two[j] ? (coef << 1) : (dig_one[j] ? coef : '0);
    assign sgn = dig_neg[j] ? ~mag : mag;
    assign pp[j] = sgn << (2 * j);
    assign corr[2*j]   = dig_neg[j];
    assign corr[2*j+1] = 1'b0;
  end
endmodule

// File: rtl/csmac_unit.sv
module csmac_unit
  import csmac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [4:0]   in_cfg,
  input  logic [N-1:0] in_coef,
  input  logic [N-1:0] in_x_sum,
  input  logic [N-1:0] in_x_carry,
  input  logic [N-1:0] in_y_sum,
  input  logic [N-1:0] in_y_carry,
  input  logic [N-1:0] in_k_sum,
  input  logic [N-1:0] in_k_carry,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_sum,
  output logic [N-1:0] out_carry
);
  localparam int G    = N / 2;
  localparam int NADD = 6;
  localparam int NV0  = G + NADD + 2;       // rows, booth corr, addends, addend corr
  localparam int NV   = NV0 + (NV0 % 2);
  localparam int NS   = (NV - 2) / 2;

  cfg_t cfg;
  assign cfg = cfg_t'(in_cfg);

  // operand conditioning: negation inverts both vectors, +2 added later
  logic [N-1:0] xs, xc, ys, yc, ks, kc, zero_v;
  assign xs = in_x_sum   ^ {N{cfg.neg_x}};
  assign xc = in_x_carry ^ {N{cfg.neg_x}};
  assign ys = in_y_sum   ^ {N{cfg.neg_y}};
  assign yc = in_y_carry ^ {N{cfg.neg_y}};
  assign ks = in_k_sum   ^ {N{cfg.neg_k}};
  assign kc = in_k_carry ^ {N{cfg.neg_k}};
  assign zero_v = '0;

  logic [2:0]   cnt_xy, cnt_k;
  logic [N-1:0] corr_xy, corr_k, corr_all;
  assign cnt_xy   = {2'b0, cfg.neg_x} + {2'b0, cfg.neg_y};
  assign cnt_k    = {2'b0, cfg.neg_k};
  assign corr_xy  = N'({cnt_xy, 1'b0});
  assign corr_k   = N'({cnt_k, 1'b0});
  assign corr_all = N'({cnt_xy + cnt_k, 1'b0});

  // routing of operands to multiplicand side and addend side
  logic [3:0][N-1:0]      mv;
  logic [N-1:0]           mcorr, acorr;
  logic [NADD-1:0][N-1:0] av;

  always_comb begin
    mv = '0; av = '0; mcorr = '0; acorr = '0;
    case (cfg.fmt)
      FMT_MAC_PRE: begin
        mv = {yc, ys, xc, xs}; mcorr = corr_xy;
        av[0] = ks; av[1] = kc; acorr = corr_k;
      end
      FMT_MAC_POST: begin
        mv[0] = ks; mv[1] = kc; mcorr = corr_k;
        av[0] = xs; av[1] = xc; av[2] = ys; av[3] = yc; acorr = corr_xy;
      end
      FMT_ADD3: begin
        av = {kc, ks, yc, ys, xc, xs}; acorr = corr_all;
      end
      FMT_MUL: begin
        mv = {yc, ys, xc, xs}; mcorr = corr_xy;
      end
      default: ;
    endcase
  end

  // multiplicand pre-reduction to one carry-save pair
  logic [N-1:0] p0s, p0c, ps, pc;
  csmac_csa42 #(.W(N)) u_pre0 (.a(mv[0]), .b(mv[1]), .c(mv[2]), .d(mv[3]), .s(p0s), .cy(p0c));
  csmac_csa42 #(.W(N)) u_pre1 (.a(p0s), .b(p0c), .c(mcorr), .d(zero_v), .s(ps), .cy(pc));

  logic [G-1:0] dig_neg, dig_one, dig_two;
  csmac_booth_recode #(.W(N)) u_recode (
    .ps(ps), .pc(pc), .dig_neg(dig_neg), .dig_one(dig_one), .dig_two(dig_two)
  );

  logic [G-1:0][N-1:0] pp;
  logic [N-1:0]        bcorr;
  csmac_ppgen #(.W(N)) u_ppgen (
    .coef(in_coef), .dig_neg(dig_neg), .dig_one(dig_one), .dig_two(dig_two),
    .pp(pp), .corr(bcorr)
  );

  // single reduction list
  logic [NV-1:0][N-1:0] vec;
  for (genvar j = 0; j < G; j++) begin : g_vpp
    assign vec[j] = pp[j];
  end
  assign vec[G] = bcorr;
  for (genvar i = 0; i < NADD; i++) begin : g_vadd
    assign vec[G+1+i] = av[i];
  end
  assign vec[G+NADD+1] = acorr;
  if (NV > NV0) begin : g_pad
    assign vec[NV-1] = '0;
  end

  logic [NS:0][N-1:0] acc_s, acc_c;
  assign acc_s[0] = vec[0];
  assign acc_c[0] = vec[1];
  for (genvar k = 0; k < NS; k++) begin : g_tree
    csmac_csa42 #(.W(N)) u_cmp (
      .a(acc_s[k]), .b(acc_c[k]), .c(vec[2*k+2]), .d(vec[2*k+3]),
      .s(acc_s[k+1]), .cy(acc_c[k+1])
    );
  end

  // output register with valid/ready
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_carry <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sum   <= acc_s[NS];
      out_carry <= acc_c[NS];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csmac_chk.sv
module csmac_chk #(
  parameter int N = 16,
  localparam int G = N / 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [4:0]   in_cfg,
  input logic [N-1:0] in_coef,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_sum,
  input logic [N-1:0] out_carry,
  input logic [G-1:0] dig_neg,
  input logic [G-1:0] dig_one,
  input logic [G-1:0] dig_two
);
  logic [N-1:0] tot;
  assign tot = out_sum + out_carry;

  // R7
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_carry));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R4
  zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_cfg[1:0] == 2'd3 && in_coef == '0 |=> tot == '0);

  for (genvar j = 0; j < G; j++) begin : g_dig
    // R6
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dig_one[j], dig_two[j]}) && (!dig_neg[j] || dig_one[j] || dig_two[j]));
  end
endmodule

bind csmac_unit csmac_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_cfg(in_cfg), .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
  .out_sum(out_sum), .out_carry(out_carry),
  .dig_neg(dig_neg), .dig_one(dig_one), .dig_two(dig_two)
);

// File: tb/test_csmac_unit.sv
`timescale 1ns/1ps
module test_csmac_unit;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [4:0]   in_cfg = '0;
  logic [N-1:0] in_coef = '0;
  logic [N-1:0] in_x_sum = '0, in_x_carry = '0, in_y_sum = '0, in_y_carry = '0;
  logic [N-1:0] in_k_sum = '0, in_k_carry = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [N-1:0] out_sum, out_carry;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  csmac_unit #(.N(N)) i_csmac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cfg(in_cfg), .in_coef(in_coef),
    .in_x_sum(in_x_sum), .in_x_carry(in_x_carry),
    .in_y_sum(in_y_sum), .in_y_carry(in_y_carry),
    .in_k_sum(in_k_sum), .in_k_carry(in_k_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_carry(out_carry)
  );

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [4:0] cfg, input logic [N-1:0] a,
      input logic [N-1:0] xs, input logic [N-1:0] xc, input logic [N-1:0] ys,
      input logic [N-1:0] yc, input logic [N-1:0] ks, input logic [N-1:0] kc);
    logic [N-1:0] x, y, k, r;
    x = xs + xc; if (cfg[2]) x = -x;
    y = ys + yc; if (cfg[3]) y = -y;
    k = ks + kc; if (cfg[4]) k = -k;
    case (cfg[1:0])
      2'd0:    r = a * (x + y) + k;
      2'd1:    r = a * k + (x + y);
      2'd2:    r = x + y + k;
      default: r = a * (x + y);
    endcase
    return r;
  endfunction

  task automatic run_op(input logic [4:0] cfg, input logic [N-1:0] a,
      input logic [N-1:0] xs, input logic [N-1:0] xc, input logic [N-1:0] ys,
      input logic [N-1:0] yc, input logic [N-1:0] ks, input logic [N-1:0] kc,
      output logic [N-1:0] s, output logic [N-1:0] c, output logic vld);
    @(negedge clk);
    in_cfg = cfg; in_coef = a;
    in_x_sum = xs; in_x_carry = xc; in_y_sum = ys; in_y_carry = yc;
    in_k_sum = ks; in_k_carry = kc;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    vld = out_valid; s = out_sum; c = out_carry;
  endtask

  task automatic rand_op(input logic [4:0] cfg, input string tag);
    logic [N-1:0] a, xs, xc, ys, yc, ks, kc, s, c, e;
    logic vld;
    a = N'($urandom); xs = N'($urandom); xc = N'($urandom);
    ys = N'($urandom); yc = N'($urandom); ks = N'($urandom); kc = N'($urandom);
    run_op(cfg, a, xs, xc, ys, yc, ks, kc, s, c, vld);
    e = model(cfg, a, xs, xc, ys, yc, ks, kc);
    check(s + c == e, tag, s + c, e);
    check(vld, {tag, " (R7 out_valid)"}, N'(vld), N'(1));
  endtask

  task automatic t_reset();
    check(!out_valid, "R9 out_valid in reset", N'(out_valid), '0);
    check(out_sum == '0 && out_carry == '0, "R9 outputs in reset", out_sum | out_carry, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R9 out_valid after reset", N'(out_valid), '0);
    check(in_ready, "R9 in_ready after reset", N'(in_ready), N'(1));
  endtask

  task automatic t_formats();
    for (int i = 0; i < 12; i++) rand_op({3'b000, 2'd0}, "R1");
    for (int i = 0; i < 12; i++) rand_op({3'b000, 2'd1}, "R2");
    for (int i = 0; i < 12; i++) rand_op({3'b000, 2'd2}, "R3");
    for (int i = 0; i < 12; i++) rand_op({3'b100, 2'd3}, "R4");
  endtask

  task automatic t_ignored();
    logic [N-1:0] s1, c1, s2, c2;
    logic v;
    // R3: coefficient change leaves result unchanged
    run_op({3'b000, 2'd2}, 16'h1234, 16'h0101, 16'h0202, 16'h0303, 16'h0404, 16'h0505, 16'h0606, s1, c1, v);
    run_op({3'b000, 2'd2}, 16'hBEEF, 16'h0101, 16'h0202, 16'h0303, 16'h0404, 16'h0505, 16'h0606, s2, c2, v);
    check(s1 + c1 == s2 + c2, "R3 coef ignored", s2 + c2, s1 + c1);
    // R4: K pair and its negate bit ignored
    run_op({3'b000, 2'd3}, 16'h0077, 16'h1111, 16'h2222, 16'h0F0F, 16'h0001, 16'h0000, 16'h0000, s1, c1, v);
    run_op({3'b100, 2'd3}, 16'h0077, 16'h1111, 16'h2222, 16'h0F0F, 16'h0001, 16'hCAFE, 16'hF00D, s2, c2, v);
    check(s1 + c1 == s2 + c2, "R4 K ignored", s2 + c2, s1 + c1);
    run_op({3'b000, 2'd3}, 16'h0000, 16'hFFFF, 16'h1357, 16'h2468, 16'hAAAA, 16'h5555, 16'h3333, s1, c1, v);
    check(s1 + c1 == '0, "R4 zero coef", s1 + c1, '0);
  endtask

  task automatic t_negate();
    for (int i = 0; i < 32; i++) begin
      logic [4:0] cfg;
      cfg = 5'(i);
      rand_op({cfg[2:0], cfg[4:3]}, "R5");
    end
  endtask

  task automatic t_corner();
    logic [N-1:0] pats [5];
    logic [N-1:0] coefs [4];
    logic [N-1:0] s, c, e;
    logic v;
    pats[0] = 16'hFFFF; pats[1] = 16'hAAAA; pats[2] = 16'h5555; pats[3] = 16'h0001; pats[4] = 16'h8000;
    coefs[0] = 16'h8000; coefs[1] = 16'hFFFF; coefs[2] = 16'h7FFF; coefs[3] = 16'h0001;
    for (int p = 0; p < 5; p++) begin
      for (int q = 0; q < 4; q++) begin
        run_op({3'b000, 2'd0}, coefs[q], pats[p], pats[p], pats[p], ~pats[p], 16'h0003, 16'h0004, s, c, v);
        e = model({3'b000, 2'd0}, coefs[q], pats[p], pats[p], pats[p], ~pats[p], 16'h0003, 16'h0004);
        check(s + c == e, "R6 pre-add multiplicand", s + c, e);
        run_op({3'b000, 2'd1}, coefs[q], 16'h0010, 16'h0020, 16'h0000, 16'h0000, pats[p], pats[p], s, c, v);
        e = model({3'b000, 2'd1}, coefs[q], 16'h0010, 16'h0020, 16'h0000, 16'h0000, pats[p], pats[p]);
        check(s + c == e, "R6 direct multiplicand", s + c, e);
      end
    end
  endtask

  task automatic t_backpressure();
    logic [N-1:0] s1, c1, e1, e2;
    e1 = model({3'b000, 2'd0}, 16'h0003, 16'h0010, 16'h0001, 16'h0002, 16'h0000, 16'h0100, 16'h0000);
    e2 = model({3'b000, 2'd2}, 16'h0000, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001);
    @(negedge clk);
    out_ready = 1'b0;
    in_cfg = {3'b000, 2'd0}; in_coef = 16'h0003;
    in_x_sum = 16'h0010; in_x_carry = 16'h0001; in_y_sum = 16'h0002; in_y_carry = 16'h0000;
    in_k_sum = 16'h0100; in_k_carry = 16'h0000;
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid, "R7 valid after take", N'(out_valid), N'(1));
    check(!in_ready, "R8 ready low on stall", N'(in_ready), '0);
    s1 = out_sum; c1 = out_carry;
    check(s1 + c1 == e1, "R8 first result", s1 + c1, e1);
    in_cfg = {3'b000, 2'd2}; in_coef = 16'h0000;
    in_x_sum = 16'h0001; in_x_carry = 16'h0001; in_y_sum = 16'h0001; in_y_carry = 16'h0001;
    in_k_sum = 16'h0001; in_k_carry = 16'h0001;
    @(negedge clk);
    check(out_sum == s1 && out_carry == c1, "R8 held during stall", out_sum + out_carry, s1 + c1);
    check(!in_ready, "R8 still blocked", N'(in_ready), '0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid, "R7 replaced on drain edge", N'(out_valid), N'(1));
    check(out_sum + out_carry == e2, "R7 second result", out_sum + out_carry, e2);
    @(negedge clk);
    check(!out_valid, "R7 valid falls after drain", N'(out_valid), '0);
  endtask

  task automatic t_chain();
    logic [N-1:0] s1, c1, s2, c2, e1, e2;
    logic v;
    for (int i = 0; i < 6; i++) begin
      logic [N-1:0] a, b;
      a = N'($urandom); b = N'($urandom);
      run_op({3'b000, 2'd0}, a, N'($urandom), N'($urandom), N'($urandom), N'($urandom),
             N'($urandom), N'($urandom), s1, c1, v);
      e1 = s1 + c1;
      run_op({3'b010, 2'd1}, b, 16'h0005, 16'h0006, 16'h0007, 16'h0008, s1, c1, s2, c2, v);
      e2 = b * e1 + (16'h000B - 16'h000F);
      check(s2 + c2 == e2, "R10 fed-back pair", s2 + c2, e2);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_formats();
    t_ignored();
    t_negate();
    t_corner();
    t_backpressure();
    t_chain();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R7 watchdog actual=hung expected=completed");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule